// File: doc/BRIEF.md
# Run-Time Configurable Asynchronous Serial Transmitter

This block converts one parallel character at a time into an asynchronous serial frame on a single logic-level line. A character is offered with a valid/ready handshake. When the block accepts it, the block captures the character and the frame settings together. The settings are the character length (7 or 8 bits), the parity mode (none, odd, even, mark or space) and the stop length (one, one-and-a-half or two bit periods).

Bit timing comes from an external tick that pulses once per clock at 16 times the bit rate. A bit period is therefore 16 ticks, and the one-and-a-half stop setting lasts 24 ticks. The line rests at logic 1. Each frame has these parts in order: a logic 0 start bit, the data bits with the least significant bit first, an optional parity bit, and then the logic 1 stop period. The busy output is high for the whole time a frame is being sent.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1, `in_ready` is 1 and `busy` is 0.
- R2: A character is accepted on a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle `txd` is 0 (the start bit), and the start bit lasts until the 16th tick after acceptance.
- R3: Data bits follow the start bit with the least significant bit first, each lasting 16 ticks. `cfg_len8`=1 sends 8 bits. `cfg_len8`=0 sends bits 6..0 only, and `in_data[7]` then has no effect on the line.
- R4: `cfg_par` encodes the parity mode: 0 none, 1 odd, 2 even, 3 mark (parity bit always 1), 4 space (parity bit always 0). Codes 5 to 7 behave as none. With none, no parity bit is sent.
- R5: With odd parity, the count of ones over the sent data bits and the parity bit is odd. With even parity, that count is even.
- R6: The stop period is logic 1. `cfg_stop` selects its length: 0 gives 16 ticks, 1 gives 24 ticks, 2 or 3 gives 32 ticks.
- R7: `in_ready` is 0 and `busy` is 1 from the cycle after acceptance until the tick that ends the stop period. After that tick `in_ready` returns to 1, so a following character can be accepted on the next edge.
- R8: The settings and the character are captured at acceptance. Changes to `in_data`, `cfg_len8`, `cfg_par` or `cfg_stop` during a frame do not affect that frame.
- R9: During a frame, `txd` changes only on a clock edge where `tick` is 1. The one exception is the start bit, which begins on the acceptance edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| in_valid | input | 1 | Character offered |
| in_data | input | 8 | Character, bit 0 sent first |
| in_ready | output | 1 | Block can accept a character |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par | input | 3 | Parity mode code |
| cfg_stop | input | 2 | Stop length code |
| txd | output | 1 | Serial line, idle 1 |
| busy | output | 1 | Frame in progress |

## Verification
A wrong bit counter or a wrong shift register makes a data or parity bit take the wrong level. This shows at the middle of the affected bit period, within 16 ticks of the fault. A wrong tick count or a wrong stop-length choice moves the point where `in_ready` returns. The bench therefore counts every tick from the fall of the start bit to the return of `in_ready`, and compares that total with the length the frame should have. If the settings are not held for the whole frame, the tail of a frame follows inputs that the bench changes right after acceptance. That fault shows in the parity bit, the data length or the stop length of the same frame.

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  input  logic       cfg_len8,
  input  logic [2:0] cfg_par,
  input  logic [1:0] cfg_stop,
  output logic       txd,
  output logic       busy
);
  localparam int CW = $clog2(2 * OVS);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  st_t            st;
  logic [8:0]     sh;
  logic [3:0]     left;
  logic [CW-1:0]  tcnt, slim;
  logic           pen, pbit;
  logic [8:0]     payload;
  logic [CW-1:0]  slim_nxt, lim;

  wire       acc   = in_valid && (st == S_IDLE);
  wire [7:0] dmask = {cfg_len8 & in_data[7], in_data[6:0]};
  wire       ones  = ^dmask;

  always_comb begin
    pen  = 1'b1;
    pbit = 1'b0;
    case (cfg_par)
      3'd1:    pbit = ~ones;
      3'd2:    pbit = ones;
      3'd3:    pbit = 1'b1;
      3'd4:    pbit = 1'b0;
      default: pen  = 1'b0;
    endcase
  end

  always_comb begin
    if (cfg_len8) payload = {pbit, dmask};
    else          payload = {1'b1, pbit, dmask[6:0]};
    case (cfg_stop)
      2'd0:    slim_nxt = CW'(OVS - 1);
      2'd1:    slim_nxt = CW'(OVS + OVS / 2 - 1);
      default: slim_nxt = CW'(2 * OVS - 1);
    endcase
  end

  assign lim      = (st == S_STOP) ? slim : CW'(OVS - 1);
  assign in_ready = (st == S_IDLE);
  assign busy     = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      txd  <= 1'b1;
      sh   <= '1;
      left <= '0;
      tcnt <= '0;
      slim <= '0;
    end else if (acc) begin
      st   <= S_START;
      txd  <= 1'b0;
      sh   <= payload;
      left <= 4'd7 + {3'd0, cfg_len8} + {3'd0, pen};
      tcnt <= '0;
      slim <= slim_nxt;
    end else if (tick && st != S_IDLE) begin
      if (tcnt == lim) begin
        tcnt <= '0;
        case (st)
          S_START, S_DATA: begin
            if (left == 4'd0) begin
              st  <= S_STOP;
              txd <= 1'b1;
            end else begin
              st   <= S_DATA;
              txd  <= sh[0];
              sh   <= {1'b1, sh[8:1]};
              left <= left - 4'd1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  // R1
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> txd);
  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (!txd && !in_ready));
  // R9
  quiet_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !acc) |=> $stable(txd));
  // R6
  stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STOP) |-> txd);
  // R6
  stop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STOP) |-> (tcnt <= slim));
endmodule

// File: tb/serial_frame_tx_bench.sv
module serial_frame_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 3;

  logic       clk = 0, rst_n = 0, tick = 0, in_valid = 0;
  logic [7:0] in_data = 0;
  logic       cfg_len8 = 0;
  logic [2:0] cfg_par = 0;
  logic [1:0] cfg_stop = 0;
  logic       in_ready, txd, busy;

  int tests = 0, fails = 0;

  typedef struct {
    logic [11:0] bits;
    int          nb;
    int          sticks;
  } frame_t;
  frame_t q[$];

  serial_frame_tx u_serial_frame_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .cfg_len8(cfg_len8), .cfg_par(cfg_par), .cfg_stop(cfg_stop),
    .txd(txd), .busy(busy));

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c = (c + 1) % TICK_DIV;
      tick = (c == 0);
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] d, logic l8, logic [2:0] p, logic [1:0] s);
    frame_t f;
    int n = l8 ? 8 : 7;
    int ones = 0;
    logic pb;
    logic has_p = 1'b1;
    for (int i = 0; i < n; i++) ones += d[i];
    case (p)
      3'd1: pb = (ones % 2 == 0);
      3'd2: pb = (ones % 2 == 1);
      3'd3: pb = 1'b1;
      3'd4: pb = 1'b0;
      default: begin pb = 1'b0; has_p = 1'b0; end
    endcase
    f.bits = '0;
    for (int i = 0; i < n; i++) f.bits[i] = d[i];
    if (has_p) f.bits[n] = pb;
    f.nb = n + (has_p ? 1 : 0);
    f.sticks = (s == 2'd0) ? 16 : (s == 2'd1) ? 24 : 32;
    q.push_back(f);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_data = d; cfg_len8 = l8; cfg_par = p; cfg_stop = s; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    // R8: disturb the inputs during the frame
    in_data = ~d; cfg_len8 = ~l8; cfg_par = p ^ 3'd3; cfg_stop = s ^ 2'd1;
  endtask

  initial begin : monitor
    forever begin
      frame_t f;
      int cnt;
      @(negedge clk);
      if (rst_n && !txd) begin
        if (q.size() == 0) begin
          check("R2 unexpected frame", 1, 0);
        end else begin
          f = q.pop_front();
          check("R7 ready low in frame", in_ready, 0);
          check("R7 busy high in frame", busy, 1);
          cnt = 0;
          for (int k = 0; k <= f.nb; k++) begin
            while (cnt < 16 * k + 8) begin
              @(posedge clk);
              if (tick) cnt++;
            end
            @(negedge clk);
            if (k == 0) check("R2 start bit", txd, 0);
            else check("R3/R4/R5 frame bit", txd, f.bits[k-1]);
          end
          while (cnt < 16 * (f.nb + 1) + 8) begin
            @(posedge clk);
            if (tick) cnt++;
          end
          @(negedge clk);
          check("R6 stop level", txd, 1);
          forever begin
            @(negedge clk);
            if (in_ready) break;
            @(posedge clk);
            if (tick) cnt++;
          end
          check("R6/R7 frame length ticks", cnt, 16 * (f.nb + 1) + f.sticks);
          check("R1 idle line", txd, 1);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset txd", txd, 1);
    check("R1 reset ready", in_ready, 1);
    check("R1 reset busy", busy, 0);
    send(8'hA5, 1, 3'd0, 2'd0);   // R3 8 bits, no parity
    send(8'hD3, 0, 3'd0, 2'd0);   // R3 bit 7 ignored in 7-bit mode
    send(8'h53, 0, 3'd0, 2'd0);
    send(8'h07, 1, 3'd1, 2'd0);   // R5 odd
    send(8'h07, 1, 3'd2, 2'd0);   // R5 even
    send(8'h3C, 0, 3'd1, 2'd2);
    send(8'h00, 1, 3'd3, 2'd1);   // R4 mark, R6 1.5 stop
    send(8'hFF, 1, 3'd4, 2'd2);   // R4 space, R6 2 stop
    send(8'h81, 0, 3'd6, 2'd3);   // R4 code 6 as none
    send(8'h5A, 1, 3'd2, 2'd1);
    send(8'h96, 0, 3'd4, 2'd1);
    send(8'h11, 1, 3'd1, 2'd2);
    while (q.size() != 0 || !in_ready) @(negedge clk);
    repeat (5) @(negedge clk);
    check("R1 idle after frames", txd, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule